// File: doc/BRIEF.md
# Multiplexed-Bus Pseudo-Static RAM Host Controller

This block is the host-side master for a pseudo-static RAM that shares one 16-bit bus between address and data. A requester issues a request that gives a start word address, a word count, a byte-lane mask, a direction and a mode, either asynchronous or synchronous burst. The controller then runs the bus phases. It drives chip select, address strobe, output enable, write enable, the two byte-lane strobes, the upper address lines and a clock-gate enable. It switches the direction of the shared bus, and it pulls write data one word at a time from the requester. Read words come back on a valid-qualified data port.

The memory runs its refresh in the background. For this to work, chip select must never stay low for longer than a bounded time, and every access must be followed by a chip-select-high interval. The controller enforces both rules. It splits long synchronous transfers into several chip-select periods and resumes each one at the next word address. It also ends a burst one clock after the memory asserts its wait signal in the middle of a burst, which is what happens when a burst reaches the end of a row. Timing is expressed purely as clock-cycle counts set by parameters.

Top module: `psram_mux_host`

## Requirements
- R1: While reset is held and on the first cycle after it, the chip select, address strobe, output enable and write enable are all high, the bus is not driven, the clock enable is low and `req_ready` is high.
- R2: An asynchronous read holds the address strobe low for T_ADDR cycles, with output and write enables high and the address driven. It then raises the address strobe, releases the bus and holds output enable low for T_ACC cycles. The bus is sampled on the last of those cycles and returned on `rd_valid`/`rd_data`. Output enable is never low while the controller drives the bus.
- R3: An asynchronous write holds write enable low from the first address cycle to the end of the access, for T_ADDR+T_WR cycles in total. It drives the write word for T_WR cycles after the address strobe rises, and keeps output enable high throughout.
- R4: During an asynchronous access the memory clock enable stays low.
- R5: While chip select is low, the low-lane strobe is low exactly when `req_be[0]` was set, and the high-lane strobe is low exactly when `req_be[1]` was set. `req_be[0]` covers bus bits [7:0] and `req_be[1]` covers bits [15:8].
- R6: A synchronous burst begins with exactly one clocked cycle in which the address strobe is low. A word then moves only on a clock where `mem_wait` is not equal to WAIT_POL, which is the active level.
- R7: Each written word is taken from `wr_data` in the cycle where `wr_take` is high, and successive words go to ascending addresses.
- R8: Chip select is never low for more than CEM_CYC consecutive cycles. A synchronous transfer that would exceed this limit is split, and it resumes at the next untransferred word address.
- R9: If wait becomes active in a synchronous burst after at least one word has moved, chip select rises on the very next clock. The remaining words then resume with a fresh address phase.
- R10: Every chip-select-low period is preceded by at least GAP_CYC cycles of chip select high, and the clock enable is low throughout those cycles. This also holds when the next access switches mode.
- R11: `done` pulses once, after the last word of a request. `req_ready` is high only when the controller is idle. A zero-length request produces `done` with no bus activity.
- R12: Read words are returned in ascending address order starting at `req_addr`, one `rd_valid` pulse per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also gated out as the memory clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sync | input | 1 | 1 = synchronous burst, 0 = asynchronous |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Number of words |
| req_be | input | 2 | Byte-lane mask for the whole request |
| wr_data | input | 16 | Current write word |
| wr_take | output | 1 | Current write word consumed at this clock |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 16 | Read word |
| done | output | 1 | Request complete pulse |
| mem_clk_en | output | 1 | Memory clock gate enable |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte-lane strobe, active low |
| mem_ub_n | output | 1 | High byte-lane strobe, active low |
| mem_a_hi | output | AW-16 | Upper word address lines |
| mem_ad_out | output | 16 | Shared bus output value |
| mem_ad_oe | output | 1 | Shared bus output enable |
| mem_ad_in | input | 16 | Shared bus input value |
| mem_wait | input | 1 | Memory wait, active level WAIT_POL |

## Verification
The bench builds the controller with T_ADDR=2, T_ACC=4, T_WR=3, GAP_CYC=3, CEM_CYC=12 and an active-low wait. With a chip-select limit of only twelve cycles, a 30-word burst has to be split several times, so resuming at the right address is exercised constantly. The bench memory model uses a 16-word row and a random refresh-collision delay, so mid-burst wait stalls and variable initial latency both occur in ordinary traffic. Choosing the non-default wait polarity proves that the polarity parameter actually reaches the logic that accepts words.

// File: rtl/pmx_pkg.sv
// Shared types for the multiplexed-bus pseudo-static RAM host controller.
// Assumes: nothing beyond IEEE 1800-2017.
package pmx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_AADDR = 3'd1,
        ST_ARD   = 3'd2,
        ST_AWR   = 3'd3,
        ST_SADDR = 3'd4,
        ST_SDAT  = 3'd5,
        ST_GAP   = 3'd6
    } pmx_state_e;
endpackage

// File: rtl/pmx_ce_guard.sv
// Counts chip-select-low cycles of the current access and flags the last
// permitted cycle. Assumes CEM_CYC >= 2 and that ce_active drops between accesses.
module pmx_ce_guard #(
    parameter int CEM_CYC = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_active,
    output logic at_limit
);
    localparam int CW = $clog2(CEM_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(CEM_CYC - 1);

    logic [CW-1:0] ce_cnt;

    // Cycle count of the running chip-select-low period.
    always_ff @(posedge clk) begin
        if (!rst_n)         ce_cnt <= '0;
        else if (ce_active) ce_cnt <= ce_cnt + 1'b1;
        else                ce_cnt <= '0;
    end

    assign at_limit = ce_active && (ce_cnt == LIMIT);

    // R8
    ce_cnt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_limit |=> !ce_active);
endmodule

// File: rtl/pmx_xfer_track.sv
// Tracks the running word address, the words still owed and whether the
// current chip-select period has moved any word. Assumes step never occurs
// with nothing left to transfer.
module pmx_xfer_track #(
    parameter int AW = 22,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    input  logic          step,
    input  logic          chunk_clr,
    output logic [AW-1:0] cur_addr,
    output logic          more,
    output logic          last,
    output logic          chunk_any
);
    logic [LW-1:0] rem;

    // Address and remaining-count bookkeeping per word moved.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem      <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            rem      <= ld_len;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            rem      <= rem - 1'b1;
        end
    end

    // Marks that the running chip-select period has moved a word.
    always_ff @(posedge clk) begin
        if (!rst_n)                chunk_any <= 1'b0;
        else if (chunk_clr || load) chunk_any <= 1'b0;
        else if (step)             chunk_any <= 1'b1;
    end

    assign more = (rem != '0);
    assign last = (rem == LW'(1));

    // R11
    rem_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem != '0));
endmodule

// File: rtl/pmx_pin_drive.sv
// Decodes the registered phase into memory pin levels and bus direction.
// Assumes AW >= 17 so the upper address lines are at least one bit wide.
module pmx_pin_drive
    import pmx_pkg::*;
#(
    parameter int AW = 22
) (
    input  pmx_state_e    state,
    input  logic          is_wr,
    input  logic [1:0]    be,
    input  logic [AW-1:0] cur_addr,
    input  logic [15:0]   wr_data,
    output logic          mem_clk_en,
    output logic          mem_ce_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [AW-17:0] mem_a_hi,
    output logic [15:0]   mem_ad_out,
    output logic          mem_ad_oe
);
    logic addr_ph, sel;

    // Pin levels as a pure function of the current phase.
    always_comb begin
        addr_ph    = (state == ST_AADDR) || (state == ST_SADDR);
        sel        = addr_ph || (state == ST_ARD) || (state == ST_AWR) || (state == ST_SDAT);
        mem_ce_n   = !sel;
        mem_adv_n  = !addr_ph;
        mem_oe_n   = !((state == ST_ARD) || ((state == ST_SDAT) && !is_wr));
        mem_we_n   = !(is_wr && sel);
        mem_ad_oe  = addr_ph || (state == ST_AWR) || ((state == ST_SDAT) && is_wr);
        mem_ad_out = addr_ph ? cur_addr[15:0] : wr_data;
        mem_lb_n   = !(sel && be[0]);
        mem_ub_n   = !(sel && be[1]);
        mem_clk_en = (state == ST_SADDR) || (state == ST_SDAT);
        mem_a_hi   = cur_addr[AW-1:16];
    end
endmodule

// File: rtl/psram_mux_host.sv
// Host controller for a pseudo-static RAM on a 16-bit multiplexed bus.
// Runs asynchronous single-word accesses and clocked bursts, paces bursts
// with the memory's wait, bounds chip-select-low time and enforces a
// chip-select-high gap after every access. Assumes T_ADDR+T_ACC and
// T_ADDR+T_WR fit in CEM_CYC, and that burst initial latency is shorter
// than CEM_CYC-1.
module psram_mux_host
    import pmx_pkg::*;
#(
    parameter int AW       = 22,
    parameter int LW       = 8,
    parameter int T_ADDR   = 2,
    parameter int T_ACC    = 14,
    parameter int T_WR     = 10,
    parameter int GAP_CYC  = 4,
    parameter int CEM_CYC  = 800,
    parameter bit WAIT_POL = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic          req_sync,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    input  logic [1:0]    req_be,
    input  logic [15:0]   wr_data,
    output logic          wr_take,
    output logic          rd_valid,
    output logic [15:0]   rd_data,
    output logic          done,
    output logic          mem_clk_en,
    output logic          mem_ce_n,
    output logic          mem_adv_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic          mem_lb_n,
    output logic          mem_ub_n,
    output logic [AW-17:0] mem_a_hi,
    output logic [15:0]   mem_ad_out,
    output logic          mem_ad_oe,
    input  logic [15:0]   mem_ad_in,
    input  logic          mem_wait
);
    localparam int PH_MAX = (T_ACC > T_WR ? T_ACC : T_WR) + T_ADDR + GAP_CYC;
    localparam int PW     = $clog2(PH_MAX + 1);
    localparam logic [PW-1:0] LIM_ADDR = PW'(T_ADDR - 1);
    localparam logic [PW-1:0] LIM_ACC  = PW'(T_ACC - 1);
    localparam logic [PW-1:0] LIM_WR   = PW'(T_WR - 1);
    localparam logic [PW-1:0] LIM_GAP  = PW'(GAP_CYC - 1);
    localparam int RW = $clog2(CEM_CYC + 2);
    localparam int GW = $clog2(GAP_CYC + 2);

    pmx_state_e    state, nxt;
    logic [PW-1:0] ph_cnt, ph_lim;
    logic          ph_last;
    logic          is_wr, is_sync;
    logic [1:0]    be_q;
    logic          load, step, more, last, chunk_any, at_limit;
    logic          wait_act, wait_ok, sync_xfer, arx_done, awx_done, sdat_end;
    logic [AW-1:0] cur_addr;

    pmx_xfer_track #(.AW(AW), .LW(LW)) i_track (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(req_addr),
        .ld_len(req_len), .step(step), .chunk_clr(state == ST_GAP),
        .cur_addr(cur_addr), .more(more), .last(last), .chunk_any(chunk_any)
    );

    pmx_ce_guard #(.CEM_CYC(CEM_CYC)) i_guard (
        .clk(clk), .rst_n(rst_n), .ce_active(!mem_ce_n), .at_limit(at_limit)
    );

    pmx_pin_drive #(.AW(AW)) i_pins (
        .state(state), .is_wr(is_wr), .be(be_q), .cur_addr(cur_addr),
        .wr_data(wr_data), .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n),
        .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_a_hi(mem_a_hi),
        .mem_ad_out(mem_ad_out), .mem_ad_oe(mem_ad_oe)
    );

    // Phase length selection and word-movement events.
    always_comb begin
        unique case (state)
            ST_AADDR: ph_lim = LIM_ADDR;
            ST_ARD:   ph_lim = LIM_ACC;
            ST_AWR:   ph_lim = LIM_WR;
            ST_GAP:   ph_lim = LIM_GAP;
            default:  ph_lim = '0;
        endcase
        ph_last   = (ph_cnt == ph_lim);
        wait_act  = (mem_wait == WAIT_POL);
        wait_ok   = !wait_act;
        sync_xfer = (state == ST_SDAT) && wait_ok;
        arx_done  = (state == ST_ARD) && ph_last;
        awx_done  = (state == ST_AWR) && ph_last;
        step      = sync_xfer || arx_done || awx_done;
        wr_take   = is_wr && (sync_xfer || awx_done);
        sdat_end  = (state == ST_SDAT) &&
                    ((wait_ok && last) || at_limit || (wait_act && chunk_any));
        req_ready = (state == ST_IDLE);
    end

    // Next-phase selection.
    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid && (req_len != '0)) begin
                load = 1'b1;
                nxt  = req_sync ? ST_SADDR : ST_AADDR;
            end
            ST_AADDR: if (ph_last) nxt = is_wr ? ST_AWR : ST_ARD;
            ST_ARD, ST_AWR: if (ph_last) nxt = ST_GAP;
            ST_SADDR: nxt = ST_SDAT;
            ST_SDAT: if (sdat_end) nxt = ST_GAP;
            ST_GAP: if (ph_last) nxt = !more ? ST_IDLE : (is_sync ? ST_SADDR : ST_AADDR);
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph_cnt <= '0;
        end else begin
            state  <= nxt;
            ph_cnt <= (nxt != state) ? '0 : ph_cnt + 1'b1;
        end
    end

    // Request attributes held for the whole transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_wr   <= 1'b0;
            is_sync <= 1'b0;
            be_q    <= 2'b00;
        end else if (state == ST_IDLE && req_valid) begin
            is_wr   <= req_write;
            is_sync <= req_sync;
            be_q    <= req_be;
        end
    end

    // Read return and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            rd_valid <= !is_wr && (sync_xfer || arx_done);
            if (!is_wr && (sync_xfer || arx_done)) rd_data <= mem_ad_in;
            done <= ((state == ST_GAP) && ph_last && !more) ||
                    ((state == ST_IDLE) && req_valid && (req_len == '0));
        end
    end

    // Checker counters: chip-select run lengths seen at the pins.
    logic [RW-1:0] ce_low_run;
    logic [GW-1:0] ce_high_run;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_low_run  <= '0;
            ce_high_run <= GW'(GAP_CYC);
        end else begin
            ce_low_run  <= mem_ce_n ? '0 :
                           (ce_low_run == RW'(CEM_CYC + 1) ? ce_low_run : ce_low_run + 1'b1);
            ce_high_run <= !mem_ce_n ? '0 :
                           (ce_high_run == GW'(GAP_CYC + 1) ? ce_high_run : ce_high_run + 1'b1);
        end
    end

    // R8
    ce_low_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (ce_low_run < RW'(CEM_CYC)));
    // R10
    ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_n) |-> (ce_high_run >= GW'(GAP_CYC)));
    // R10
    gap_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> !mem_clk_en);
    // R4
    async_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !is_sync) |-> !mem_clk_en);
    // R2
    adv_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_adv_n |-> (mem_oe_n && mem_ad_oe));
    // R2
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_ad_oe);
    // R6
    sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(mem_clk_en)) |-> ($past(mem_wait) != WAIT_POL));
    // R9
    stall_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SDAT) && wait_act && chunk_any) |=> mem_ce_n);
endmodule

// File: tb/test_psram_mux_host.sv
module test_psram_mux_host;
    localparam int AW = 22, LW = 8;
    localparam int T_ADDR = 2, T_ACC = 4, T_WR = 3, GAP_CYC = 3, CEM_CYC = 12;
    localparam bit WP = 1'b0;
    localparam int LAT = 3, STALL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = !clk;

    logic          req_valid = 1'b0, req_write = 1'b0, req_sync = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic [1:0]    req_be = 2'b11;
    logic [15:0]   wr_data = '0;
    logic req_ready, wr_take, rd_valid, done;
    logic [15:0] rd_data;
    logic mem_clk_en, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_ad_oe;
    logic [AW-17:0] mem_a_hi;
    logic [15:0] mem_ad_out, mem_ad_in;
    logic mem_wait;

    psram_mux_host #(.AW(AW), .LW(LW), .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_WR(T_WR),
        .GAP_CYC(GAP_CYC), .CEM_CYC(CEM_CYC), .WAIT_POL(WP)) i_psram_mux_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_sync(req_sync), .req_addr(req_addr),
        .req_len(req_len), .req_be(req_be), .wr_data(wr_data), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .mem_clk_en(mem_clk_en), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
        .mem_ub_n(mem_ub_n), .mem_a_hi(mem_a_hi), .mem_ad_out(mem_ad_out),
        .mem_ad_oe(mem_ad_oe), .mem_ad_in(mem_ad_in), .mem_wait(mem_wait));

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n, input logic [1:0] be);
        return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
    endfunction

    // Behavioural memory on the pins.
    logic [15:0] mem_arr [256];
    logic [15:0] ref_arr [256];
    logic [7:0]  ptr = '0;
    int          waitc = 0;
    logic        m_sync = 1'b0;
    logic        p_we = 1'b1, p_lb = 1'b1, p_ub = 1'b1;
    logic [15:0] p_ad = '0;
    assign mem_ad_in = mem_arr[ptr];
    assign mem_wait  = (waitc != 0) ? WP : !WP;

    always @(posedge clk) begin
        p_we <= mem_we_n; p_ad <= mem_ad_out; p_lb <= mem_lb_n; p_ub <= mem_ub_n;
        if (!mem_ce_n && !mem_adv_n) begin
            ptr <= mem_ad_out[7:0];
            m_sync <= mem_clk_en;
            if (mem_clk_en) waitc <= LAT + int'($urandom % 3);
        end else if (!mem_ce_n && mem_clk_en) begin
            if (waitc > 0) waitc <= waitc - 1;
            else begin
                if (!mem_we_n) mem_arr[ptr] <= merge(mem_arr[ptr], mem_ad_out, {!mem_ub_n, !mem_lb_n});
                ptr <= ptr + 8'd1;
                if (ptr[3:0] == 4'hF) waitc <= STALL;
            end
        end
        if (!m_sync && !p_we && mem_we_n)
            mem_arr[ptr] <= merge(mem_arr[ptr], p_ad, {!p_ub, !p_lb});
    end

    // Write word feeder.
    logic [15:0] wq [64];
    int widx = 0;
    initial forever begin
        @(negedge clk);
        if (wr_take) begin
            @(posedge clk); #1;
            widx = widx + 1;
            wr_data = wq[widx % 64];
        end
    end

    // Request context seen by the monitors.
    bit cur_sync = 0, cur_wr = 0;
    logic [1:0] cur_be = 2'b11;
    int rd_base = 0, ridx = 0, ce_starts = 0;

    // Read return scoreboard (R12).
    always @(negedge clk) if (rst_n && rd_valid) begin
        chk(rd_data == ref_arr[(rd_base + ridx) % 256], "R12 read word",
            int'(rd_data), int'(ref_arr[(rd_base + ridx) % 256]));
        ridx++;
    end

    // Pin protocol monitor.
    logic prev_ce = 1'b1;
    int ce_run = 0, gap_run = 100, adv_run = 0, oe_run = 0, we_run = 0, xfers = 0, stall = 0;
    bit be_bad = 0, ov_bad = 0, clk_bad = 0, gap_clk_bad = 0;
    always @(negedge clk) if (rst_n) begin
        if (!mem_ce_n) begin
            if (prev_ce) begin
                ce_starts++;
                chk(gap_run >= GAP_CYC, "R10 gap before access", gap_run, GAP_CYC);
                chk(!gap_clk_bad, "R10 clock off in gap", int'(gap_clk_bad), 0);
                ce_run = 0; adv_run = 0; oe_run = 0; we_run = 0; xfers = 0; stall = 0;
                be_bad = 0; ov_bad = 0; clk_bad = 0; gap_clk_bad = 0;
            end
            ce_run++;
            if (!mem_adv_n) adv_run++;
            if (!mem_oe_n) oe_run++;
            if (!mem_we_n) we_run++;
            if (mem_lb_n != !cur_be[0] || mem_ub_n != !cur_be[1]) be_bad = 1;
            if ((!mem_adv_n && !mem_oe_n) || (!mem_oe_n && mem_ad_oe)) ov_bad = 1;
            if (!cur_sync && mem_clk_en) clk_bad = 1;
            if (mem_clk_en && mem_adv_n) begin
                if (mem_wait == WP) begin if (xfers > 0) stall++; end
                else xfers++;
            end
        end else begin
            if (!prev_ce) begin
                chk(ce_run <= CEM_CYC, "R8 chip-select low run", ce_run, CEM_CYC);
                chk(!be_bad, "R5 lane strobes", int'(be_bad), 0);
                chk(!ov_bad, "R2 output enable vs bus drive", int'(ov_bad), 0);
                chk(stall <= 1, "R9 stall cycles before release", stall, 1);
                if (!cur_sync) begin
                    chk(!clk_bad, "R4 clock static in async", int'(clk_bad), 0);
                    chk(adv_run == T_ADDR, "R2 R3 address cycles", adv_run, T_ADDR);
                    if (cur_wr) chk(we_run == T_ADDR + T_WR, "R3 write enable cycles", we_run, T_ADDR + T_WR);
                    else        chk(oe_run == T_ACC, "R2 output enable cycles", oe_run, T_ACC);
                end else begin
                    chk(adv_run == 1, "R6 single address clock", adv_run, 1);
                end
                gap_run = 0;
            end
            gap_run++;
            if (mem_clk_en) gap_clk_bad = 1;
        end
        prev_ce = mem_ce_n;
    end

    task automatic do_req(input bit s, input bit w, input int a, input int n, input logic [1:0] be);
        int t;
        for (int i = 0; i < n; i++) begin
            if (w) begin
                wq[i] = 16'($urandom);
                ref_arr[(a + i) % 256] = merge(ref_arr[(a + i) % 256], wq[i], be);
            end
        end
        widx = 0; wr_data = wq[0];
        cur_sync = s; cur_wr = w; cur_be = be; rd_base = a; ridx = 0;
        @(negedge clk);
        req_valid = 1'b1; req_sync = s; req_write = w;
        req_addr = AW'(a); req_len = LW'(n); req_be = be;
        @(posedge clk); #1;
        req_valid = 1'b0;
        t = 0;
        @(negedge clk);
        if (n != 0) chk(!req_ready, "R11 ready low while busy", int'(req_ready), 0);
        while (!done && t < 3000) begin @(negedge clk); t++; end
        chk(done, "R11 done pulse", int'(done), 1);
        if (!w) chk(ridx == n, "R12 read word count", ridx, n);
        @(negedge clk);
        chk(!done && req_ready, "R11 single done, ready again", int'(done), 0);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int s0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) begin
            mem_arr[i] = 16'(i * 16'h9E37) ^ 16'h5A5A;
            ref_arr[i] = mem_arr[i];
        end
        for (int i = 0; i < 64; i++) wq[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n, "R1 strobes high in reset", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_adv_n && mem_oe_n && mem_we_n && !mem_ad_oe && !mem_clk_en && req_ready,
            "R1 idle after reset", int'({mem_ce_n, mem_ad_oe, mem_clk_en, req_ready}), 4'b1001);

        do_req(0, 0, 10, 1, 2'b11);        // R2 async read
        do_req(0, 1, 20, 2, 2'b11);        // R3 R7 async write
        do_req(0, 0, 20, 2, 2'b11);
        do_req(0, 1, 30, 1, 2'b01);        // R5 low lane only
        do_req(0, 0, 30, 1, 2'b11);
        do_req(1, 1, 40, 30, 2'b11);       // R7 R8 R9 sync write split, row stalls
        do_req(1, 0, 40, 30, 2'b11);       // R6 R8 R9 sync read back
        do_req(1, 1, 60, 3, 2'b10);        // R5 high lane only, sync
        do_req(0, 0, 60, 3, 2'b11);        // R10 mode switch
        s0 = ce_starts;
        do_req(1, 0, 12, 0, 2'b11);        // R11 zero length
        chk(ce_starts == s0, "R11 zero length no bus activity", ce_starts - s0, 0);

        for (int k = 0; k < 40; k++) begin
            bit s = 1'($urandom), w = 1'($urandom);
            int n = s ? 1 + int'($urandom % 40) : 1 + int'($urandom % 5);
            logic [1:0] be = 2'(1 + $urandom % 3);
            do_req(s, w, int'($urandom % 200), n, w ? be : 2'b11);
        end
        do_req(1, 0, 0, 250, 2'b11);       // R12 whole-region readback
        summary();
    end
endmodule